// File: doc/BRIEF.md
# Serial Channel Code Programming Port

This block is the programming front end of a multi-channel reference voltage generator. A host writes 11-bit output codes into a bank of nineteen registers over a three-wire serial link: eighteen output channels and one common-voltage channel. Each transfer is a 16-bit word. A 5-bit channel address comes first, followed by the 11-bit code. The stored codes are presented in parallel to a downstream refresh engine. That engine and the analog path are outside this block.

The serial pins are asynchronous to the block clock. Chip-select, serial clock, serial data and the read/write select pass through a parameterised synchronizer, and edges are detected in the clock domain. A write takes effect only when chip-select goes high again after a whole frame. With the read/write select high, the block instead returns the addressed register on the serial output. The data bits change on falling serial-clock edges, after the address has been received.

Top module: `gamma_prog_if`

## Requirements
- R1: While `rst_n` is low, every channel code and the common code read 0 and `sdo` is 0. They stay so after reset until a write commits.
- R2: Serial data is sampled on rising `sclk` edges while `cs_n` is low, most significant bit first. In a 16-bit frame, bits 15..11 are the channel address and bits 10..0 are the code. With `rd_sel`=0 the frame is a write.
- R3: Addresses 0 to 17 select output channels 0 to 17 (slice `out_codes[11*a +: 11]`). Address 18 selects `com_code`. A write to any address from 19 to 31 changes no output.
- R4: The addressed code changes only after `cs_n` rises at the end of the frame. It is visible within 6 clock cycles of that rise, and no output changes while `cs_n` is low.
- R5: If `cs_n` rises after fewer than 16 bits, the frame is dropped and no output changes.
- R6: If more than 16 bits arrive before `cs_n` rises, only the last 16 received form the frame.
- R7: While `cs_n` is high, `sclk` and `sdi` activity is ignored: no bit is counted, and `sdo` stays 0.
- R8: With `rd_sel`=1, the five address bits are taken from the first five bits of the frame. On each of the next eleven falling `sclk` edges, `sdo` presents the addressed 11-bit code, most significant bit first. A read frame changes no output.
- R9: A read of an address from 19 to 31 returns all zeros on `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; must run well above the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset, clears all codes |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, most significant bit first |
| rd_sel | input | 1 | Access select: 0 write, 1 read |
| sdo | output | 1 | Serial data out for reads, 0 when idle |
| out_codes | output | 198 | Eighteen 11-bit channel codes, channel n at bits 11n+10..11n |
| com_code | output | 11 | Common-voltage channel code |

## Verification
The assertions assume that `rd_sel` is held steady for the whole of a frame. They also assume that every serial level lasts several block clock cycles, so the synchronizer never misses an `sclk` phase. The stimulus keeps `rd_sel` fixed from before `cs_n` falls until after it rises. It holds each `sclk` phase for ten clock cycles and sets `sdi` five cycles before each rising edge. Under these conditions the assertions check three things: no code moves while the frame is open or during a read, the bit counter never exceeds the frame length, and `sdo` is quiet whenever chip-select is high.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

   typedef enum logic {
      ACC_WRITE = 1'b0,
      ACC_READ  = 1'b1
   } acc_mode_e;

   // Bit positions of the synchronized serial bus inside the sync vector
   localparam int SB_CS   = 3;
   localparam int SB_SCLK = 2;
   localparam int SB_SDI  = 1;
   localparam int SB_RD   = 0;
   localparam int SB_W    = 4;

endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
   parameter int              WIDTH   = 4,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "gpi_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain[0] <= RST_VAL;
      end else begin
         chain[0] <= d;
      end
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= RST_VAL;
            end else begin
               chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_prev <= RST_VAL;
      end else begin
         q_prev <= chain[STAGES-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpi_frame_rx.sv
module gpi_frame_rx #(
   parameter int ADDR_W = 5,
   parameter int CODE_W = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       active,
   input  logic                       bit_stb,
   input  logic                       bit_in,
   output logic [ADDR_W+CODE_W-1:0]   frame,
   output logic                       full,
   output logic                       addr_stb,
   output logic [ADDR_W-1:0]          addr_early
);

   localparam int FRAME_W = ADDR_W + CODE_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W - 1);

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   cnt;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $fatal(1, "gpi_frame_rx: ADDR_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (!active) begin
         cnt <= '0;
      end else if (bit_stb) begin
         shreg <= {shreg[FRAME_W-2:0], bit_in};
         if (cnt != CNT_FULL) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign frame      = shreg;
   assign full       = (cnt == CNT_FULL);
   assign addr_stb   = active && bit_stb && (cnt == CNT_ADDR);
   assign addr_early = {shreg[ADDR_W-2:0], bit_in};

   // R6: the counter saturates at the frame length
   p_cnt_bounded_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL);

   // R7: bits are only strobed while the frame is selected
   p_strobe_gated_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> active);

endmodule

// File: rtl/gpi_code_bank.sv
module gpi_code_bank #(
   parameter int N_CH   = 19,
   parameter int ADDR_W = 5,
   parameter int CODE_W = 11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [CODE_W-1:0]        wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [N_CH*CODE_W-1:0]   codes_flat,
   output logic [CODE_W-1:0]        rd_data
);

   logic [CODE_W-1:0] regs [N_CH];

   generate
      if (N_CH > (1 << ADDR_W)) begin : g_bad_depth
         $fatal(1, "gpi_code_bank: N_CH exceeds the address space");
      end
      for (genvar i = 0; i < N_CH; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[i] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
               regs[i] <= wr_data;
            end
         end
         assign codes_flat[i*CODE_W +: CODE_W] = regs[i];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (rd_addr == ADDR_W'(i)) begin
            rd_data = regs[i];
         end
      end
   end

   // R4: the bank holds its contents unless a commit is issued
   p_bank_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(codes_flat));

   // R3: commits only target implemented channels
   p_write_in_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < N_CH));

endmodule

// File: rtl/gpi_readout.sv
module gpi_readout #(
   parameter int CODE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              load,
   input  logic [CODE_W-1:0] load_data,
   input  logic              shift_stb,
   output logic              sdo
);

   logic [CODE_W-1:0] out_sh;
   logic              armed;
   logic              sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sh <= '0;
         armed  <= 1'b0;
         sdo_q  <= 1'b0;
      end else if (!active) begin
         armed <= 1'b0;
         sdo_q <= 1'b0;
      end else if (load) begin
         out_sh <= load_data;
         armed  <= 1'b1;
      end else if (shift_stb && armed) begin
         sdo_q  <= out_sh[CODE_W-1];
         out_sh <= {out_sh[CODE_W-2:0], 1'b0};
      end
   end

   assign sdo = sdo_q;

   // R7: output is quiet once the frame is deselected
   p_sdo_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !sdo);

endmodule

// File: rtl/gamma_prog_if.sv
module gamma_prog_if #(
   parameter int N_OUT       = 18,
   parameter int ADDR_W      = 5,
   parameter int CODE_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic                      sclk,
   input  logic                      sdi,
   input  logic                      rd_sel,
   output logic                      sdo,
   output logic [N_OUT*CODE_W-1:0]   out_codes,
   output logic [CODE_W-1:0]         com_code
);
   import gpi_pkg::*;

   localparam int N_CH    = N_OUT + 1;
   localparam int FRAME_W = ADDR_W + CODE_W;

   generate
      if (N_CH > (1 << ADDR_W)) begin : g_bad_map
         $fatal(1, "gamma_prog_if: channels do not fit the address field");
      end
      if (CODE_W < 2) begin : g_bad_code
         $fatal(1, "gamma_prog_if: CODE_W must be at least 2");
      end
   endgenerate

   logic [SB_W-1:0] s_now, s_prev;
   logic            active, sclk_rise, sclk_fall, cs_rise;
   acc_mode_e       mode;

   gpi_sync #(
      .WIDTH   (SB_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1000)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      ({cs_n, sclk, sdi, rd_sel}),
      .q      (s_now),
      .q_prev (s_prev)
   );

   assign active    = !s_now[SB_CS];
   assign sclk_rise = active && s_now[SB_SCLK] && !s_prev[SB_SCLK];
   assign sclk_fall = active && !s_now[SB_SCLK] && s_prev[SB_SCLK];
   assign cs_rise   = s_now[SB_CS] && !s_prev[SB_CS];
   assign mode      = acc_mode_e'(s_now[SB_RD]);

   logic [FRAME_W-1:0] frame;
   logic               full, addr_stb;
   logic [ADDR_W-1:0]  addr_early;

   gpi_frame_rx #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .bit_stb    (sclk_rise),
      .bit_in     (s_now[SB_SDI]),
      .frame      (frame),
      .full       (full),
      .addr_stb   (addr_stb),
      .addr_early (addr_early)
   );

   logic [ADDR_W-1:0] wr_addr;
   logic [CODE_W-1:0] wr_data;
   logic              wr_en;
   logic [N_CH*CODE_W-1:0] codes_flat;
   logic [CODE_W-1:0] rd_data;

   assign wr_addr = frame[FRAME_W-1:CODE_W];
   assign wr_data = frame[CODE_W-1:0];
   assign wr_en   = cs_rise && full && (mode == ACC_WRITE) &&
                    (int'(wr_addr) < N_CH);

   gpi_code_bank #(
      .N_CH   (N_CH),
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (addr_early),
      .codes_flat (codes_flat),
      .rd_data    (rd_data)
   );

   gpi_readout #(
      .CODE_W (CODE_W)
   ) u_rdo (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .load      (addr_stb && (mode == ACC_READ)),
      .load_data (rd_data),
      .shift_stb (sclk_fall),
      .sdo       (sdo)
   );

   assign out_codes = codes_flat[N_OUT*CODE_W-1:0];
   assign com_code  = codes_flat[N_CH*CODE_W-1 -: CODE_W];

   // R4: outputs never move while a frame is open
   p_no_update_in_frame_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      active |=> ($stable(out_codes) && $stable(com_code)));

   // R8: a read access never alters a stored code
   p_read_no_write_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == ACC_READ) |=> ($stable(out_codes) && $stable(com_code)));

endmodule

// File: tb/gamma_prog_if_tb.sv
module gamma_prog_if_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic rd_sel = 1'b0;
   logic sdo;
   logic [197:0] out_codes;
   logic [10:0]  com_code;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [10:0] model [19];

   always #5 clk = ~clk;

   gamma_prog_if u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .rd_sel    (rd_sel),
      .sdo       (sdo),
      .out_codes (out_codes),
      .com_code  (com_code)
   );

   function automatic logic [10:0] code_of(input int ch);
      if (ch == 18) return com_code;
      return out_codes[ch*11 +: 11];
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < 19; c++) begin
         check(code_of(c) === model[c], req, code_of(c), model[c]);
      end
   endtask

   // Shift nbits of word, MSB first; optionally close the frame.
   task automatic xfer(input int nbits, input logic [31:0] word, input logic rd,
                       input bit close, output logic [10:0] got);
      got = '0;
      rd_sel = rd;
      wait_clk(3);
      cs_n = 1'b0;
      wait_clk(5);
      for (int k = 0; k < nbits; k++) begin
         sdi = word[nbits-1-k];
         wait_clk(5);
         if (k >= 5 && k < 16) got[10-(k-5)] = sdo;
         sclk = 1'b1;
         wait_clk(10);
         sclk = 1'b0;
         wait_clk(5);
      end
      wait_clk(5);
      if (close) begin
         cs_n = 1'b1;
         wait_clk(8);
      end
   endtask

   task automatic write_ch(input int addr, input logic [10:0] val);
      logic [10:0] g;
      xfer(16, {16'd0, 5'(addr), val}, 1'b0, 1'b1, g);
      if (addr < 19) model[addr] = val;
   endtask

   task automatic t_reset;
      for (int c = 0; c < 19; c++) model[c] = '0;
      check_all("R1");
      check(sdo === 1'b0, "R1", sdo, 0);
   endtask

   task automatic t_basic_writes;
      write_ch(0, 11'h5A3);
      write_ch(17, 11'h7FF);
      write_ch(18, 11'h2C1);
      write_ch(9, 11'h001);
      check(code_of(0) === 11'h5A3, "R2", code_of(0), 11'h5A3);
      check(code_of(17) === 11'h7FF, "R3", code_of(17), 11'h7FF);
      check(com_code === 11'h2C1, "R3", com_code, 11'h2C1);
      check_all("R2");
   endtask

   task automatic t_out_of_range;
      write_ch(19, 11'h3AA);
      write_ch(31, 11'h155);
      check_all("R3");
   endtask

   task automatic t_commit_timing;
      logic [10:0] g;
      xfer(16, {16'd0, 5'd4, 11'h6B2}, 1'b0, 1'b0, g);
      check(code_of(4) === model[4], "R4", code_of(4), model[4]);
      cs_n = 1'b1;
      wait_clk(6);
      model[4] = 11'h6B2;
      check(code_of(4) === 11'h6B2, "R4", code_of(4), 11'h6B2);
   endtask

   task automatic t_short_frame;
      logic [10:0] g;
      xfer(15, {17'd0, 4'd2, 11'h444}, 1'b0, 1'b1, g);
      xfer(10, {22'd0, 10'h3C5}, 1'b0, 1'b1, g);
      check_all("R5");
   endtask

   task automatic t_long_frame;
      logic [10:0] g;
      // 4 leading junk bits 1111, then address 6 with code 0x0F0
      xfer(20, {12'd0, 4'hF, 5'd6, 11'h0F0}, 1'b0, 1'b1, g);
      model[6] = 11'h0F0;
      check(code_of(6) === 11'h0F0, "R6", code_of(6), 11'h0F0);
      check_all("R6");
   endtask

   task automatic t_deselected_activity;
      logic [10:0] g;
      for (int k = 0; k < 7; k++) begin
         sdi = k[0];
         wait_clk(5);
         sclk = 1'b1;
         wait_clk(5);
         check(sdo === 1'b0, "R7", sdo, 0);
         sclk = 1'b0;
         wait_clk(5);
      end
      write_ch(11, 11'h321);
      check(code_of(11) === 11'h321, "R7", code_of(11), 11'h321);
      check_all("R7");
   endtask

   task automatic t_readback;
      logic [10:0] g;
      xfer(16, {16'd0, 5'd0, 11'h000}, 1'b1, 1'b1, g);
      check(g === model[0], "R8", g, model[0]);
      xfer(16, {16'd0, 5'd18, 11'h7FF}, 1'b1, 1'b1, g);
      check(g === model[18], "R8", g, model[18]);
      xfer(16, {16'd0, 5'd6, 11'h000}, 1'b1, 1'b1, g);
      check(g === model[6], "R8", g, model[6]);
      check_all("R8");
      rd_sel = 1'b0;
   endtask

   task automatic t_read_unmapped;
      logic [10:0] g;
      xfer(16, {16'd0, 5'd25, 11'h000}, 1'b1, 1'b1, g);
      check(g === 11'h000, "R9", g, 0);
      rd_sel = 1'b0;
   endtask

   task automatic t_reset_again;
      wait_clk(2);
      rst_n = 1'b0;
      wait_clk(3);
      for (int c = 0; c < 19; c++) model[c] = '0;
      check_all("R1");
      rst_n = 1'b1;
      wait_clk(5);
      check_all("R1");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      wait_clk(4);
      t_reset;
      rst_n = 1'b1;
      wait_clk(5);
      t_reset;
      t_basic_writes;
      t_out_of_range;
      t_commit_timing;
      t_short_frame;
      t_long_frame;
      t_deselected_activity;
      t_readback;
      t_read_unmapped;
      t_reset_again;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule